// File: doc/BRIEF.md
# Bus Backoff Cycle Restart Controller

This block sequences the bus cycles of a processor bus master on a bus where system logic can force the master off at any clock through a backoff input. The core hands it one cycle descriptor at a time: address, direction, burst length and lock markers. The block drives an address strobe, counts burst-ready beats and reports when a cycle completes. A snoop writeback request from the cache side is issued as a four-beat write burst. It is acknowledged when its last beat arrives.

When backoff is raised, the cycle on the bus is abandoned at once, whatever beats it had already received. Once backoff drops, the block replays that cycle from its first beat. A pending snoop writeback always goes ahead of the replay. Completed cycles are never replayed. The lock output stays up from the first locked cycle until the cycle marked as the end of the sequence finishes, including across any backoff. While backed off, a stalled core keeps the bus request output raised.

Top module: `bkoff_seq`

## Requirements
- R1: While backoff is high, no cycle completes. A burst-ready in the same clock as backoff is not counted, even on the final beat, and that cycle is later run again in full.
- R2: A replayed cycle begins with beat index 0 at its strobe. It needs `req_len`+1 burst-ready beats before `core_done` pulses.
- R3: No strobe is driven while backoff is high in the current and previous clocks. After an abort in the data phase, the replay strobe appears in the clock after the first clock with backoff low, and not in that first clock.
- R4: After a cycle completes (`core_done` or `wb_ack`), the next clock has no strobe. If work is queued, the strobe follows in the clock after that.
- R5: If backoff rises in the clock in which the strobe is driven, the strobe is driven again in the first clock with backoff low. The data phase then follows directly, with beat index 0 and no further strobe. This applies when no writeback is pending.
- R6: A cycle whose final beat was accepted is not run again if backoff arrives afterwards. The next strobe carries the next request.
- R7: A writeback that is pending when backoff drops is issued first. It is a write (`bus_write`=1) to `wb_addr` of `WB_LEN`+1 beats, ending with a `wb_ack` pulse, and only then is the aborted core cycle replayed.
- R8: While backoff and `core_stall` are both high, `bus_req` is high in every clock. With no queued work, no cycle on the bus and no stall, `bus_req` is low.
- R9: `bus_lock` rises with the strobe of a cycle that has `req_lock`=1. It stays high through backoff and writebacks until the completion of the cycle that has `req_lock_last`=1, and is low in the clock after that.
- R10: After reset, `bus_ads`, `bus_req` and `bus_lock` are low and `req_ready` is high.
- R11: A request with length field `req_len`=n runs n+1 beats. `bus_beat` shows beat indices 0 to n in the clocks where they are accepted, and `core_done` pulses on beat n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core offers a cycle descriptor |
| req_ready | output | 1 | Descriptor slot is empty |
| req_addr | input | AW | Cycle address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LW | Beats minus one |
| req_lock | input | 1 | Cycle belongs to a locked sequence |
| req_lock_last | input | 1 | Cycle ends the locked sequence |
| core_stall | input | 1 | Core cannot progress without the bus |
| wb_req | input | 1 | Snoop writeback pending, held until `wb_ack` |
| wb_addr | input | AW | Writeback address, stable while `wb_req` is high |
| wb_ack | output | 1 | Final beat of the writeback accepted |
| core_done | output | 1 | Final beat of the core cycle accepted |
| backoff | input | 1 | System forces the master off the bus |
| bus_brdy | input | 1 | Burst-ready data beat |
| bus_ads | output | 1 | Address strobe |
| bus_addr | output | AW | Address of the cycle on the bus |
| bus_write | output | 1 | Direction of the cycle on the bus |
| bus_lock | output | 1 | Locked sequence in progress |
| bus_req | output | 1 | Bus request |
| bus_beat | output | LW | Index of the beat expected next |

## Verification
The hardest case to reach from the ports is backoff that coincides exactly with the strobe. It needs a different release sequence from an abort in the data phase. The bench waits for the strobe, then raises backoff in that same clock before the edge. A second hard case is backoff that coincides with the final beat of a replay. It is reached by counting beats from the strobe and raising backoff on the last one, so that the cycle must run a third time. Writeback priority is set up by raising the snoop request only while the bus is backed off. The first strobe after release must then carry the writeback address.

// File: rtl/bkoff_seq.sv
module bkoff_seq #(
  parameter int AW = 32,
  parameter int LW = 2,
  parameter logic [LW-1:0] WB_LEN = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [LW-1:0] req_len,
  input  logic          req_lock,
  input  logic          req_lock_last,
  input  logic          core_stall,
  input  logic          wb_req,
  input  logic [AW-1:0] wb_addr,
  output logic          wb_ack,
  output logic          core_done,
  input  logic          backoff,
  input  logic          bus_brdy,
  output logic          bus_ads,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          bus_lock,
  output logic          bus_req,
  output logic [LW-1:0] bus_beat
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_GAP, S_HELD} st_t;

  st_t           st, st_n;
  logic          cur_valid, cur_write, cur_lock, cur_last;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] cur_len, beat;
  logic          act_wb, stuck, lock_on, launch;

  wire           work      = cur_valid | wb_req;
  wire           in_flight = (st == S_ADDR) || (st == S_DATA);
  wire           stuck_go  = (st == S_HELD) && !backoff && stuck && cur_valid && !wb_req;
  wire [LW-1:0]  act_len   = act_wb ? WB_LEN : cur_len;
  wire           last_beat = (st == S_DATA) && bus_brdy && !backoff && (beat == act_len);

  assign req_ready = !cur_valid;
  assign core_done = last_beat && !act_wb;
  assign wb_ack    = last_beat && act_wb;
  assign bus_ads   = (st == S_ADDR) || stuck_go;
  assign bus_addr  = act_wb ? wb_addr : cur_addr;
  assign bus_write = act_wb | cur_write;
  assign bus_lock  = lock_on | (bus_ads & !act_wb & cur_lock);
  assign bus_req   = work | in_flight | (backoff & core_stall);
  assign bus_beat  = beat;

  always_comb begin
    st_n   = st;
    launch = 1'b0;
    if (backoff) st_n = S_HELD;
    else begin
      case (st)
        S_IDLE: launch = work;
        S_ADDR: st_n = S_DATA;
        S_DATA: if (bus_brdy && beat == act_len) st_n = S_GAP;
        S_GAP:  if (work) launch = 1'b1; else st_n = S_IDLE;
        S_HELD: if (stuck_go) st_n = S_DATA;
                else if (work) launch = 1'b1;
                else st_n = S_IDLE;
        default: st_n = S_IDLE;
      endcase
      if (launch) st_n = S_ADDR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_valid <= 1'b0;
      cur_addr  <= '0;
      cur_write <= 1'b0;
      cur_len   <= '0;
      cur_lock  <= 1'b0;
      cur_last  <= 1'b0;
      act_wb    <= 1'b0;
      beat      <= '0;
      stuck     <= 1'b0;
      lock_on   <= 1'b0;
    end else begin
      st <= st_n;
      if (req_valid && req_ready) begin
        cur_valid <= 1'b1;
        cur_addr  <= req_addr;
        cur_write <= req_write;
        cur_len   <= req_len;
        cur_lock  <= req_lock;
        cur_last  <= req_lock_last;
      end else if (core_done) begin
        cur_valid <= 1'b0;
      end
      if (launch) act_wb <= wb_req;
      if (st_n != S_DATA) beat <= '0;
      else if (st == S_DATA && bus_brdy) beat <= beat + 1'b1;
      stuck <= backoff && ((st == S_ADDR) || (st == S_HELD && stuck));
      if (core_done && cur_last) lock_on <= 1'b0;
      else if (bus_ads && !act_wb && cur_lock) lock_on <= 1'b1;
    end
  end

endmodule

// File: rtl/bkoff_seq_chk.sv
module bkoff_seq_chk #(
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          backoff,
  input logic          core_stall,
  input logic          bus_ads,
  input logic [LW-1:0] bus_beat,
  input logic          bus_req,
  input logic          bus_lock,
  input logic          core_done,
  input logic          wb_ack
);

  assert_no_done_in_backoff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    backoff |-> (!core_done && !wb_ack));

  assert_strobe_beat_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads |-> (bus_beat == '0));

  assert_no_strobe_when_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (backoff && $past(backoff)) |-> !bus_ads);

  assert_idle_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done || wb_ack) |=> !bus_ads);

  assert_single_completion_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_done && wb_ack));

  assert_req_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (backoff && core_stall) |-> bus_req);

  assert_lock_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && !core_done) |=> bus_lock);

endmodule

bind bkoff_seq bkoff_seq_chk #(.LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .backoff(backoff), .core_stall(core_stall),
  .bus_ads(bus_ads), .bus_beat(bus_beat), .bus_req(bus_req), .bus_lock(bus_lock),
  .core_done(core_done), .wb_ack(wb_ack)
);

// File: tb/bkoff_seq_tb.sv
module bkoff_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_lock = 1'b0, req_lock_last = 1'b0;
  logic [AW-1:0] req_addr = '0, wb_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          core_stall = 1'b0, wb_req = 1'b0, backoff = 1'b0, bus_brdy = 1'b0;
  logic          req_ready, wb_ack, core_done, bus_ads, bus_write, bus_lock, bus_req;
  logic [AW-1:0] bus_addr;
  logic [LW-1:0] bus_beat;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkoff_seq #(.AW(AW), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_len(req_len), .req_lock(req_lock),
    .req_lock_last(req_lock_last), .core_stall(core_stall), .wb_req(wb_req),
    .wb_addr(wb_addr), .wb_ack(wb_ack), .core_done(core_done), .backoff(backoff),
    .bus_brdy(bus_brdy), .bus_ads(bus_ads), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_lock(bus_lock), .bus_req(bus_req), .bus_beat(bus_beat)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_req(input logic [AW-1:0] a, input bit wr, input int len, input bit lk, input bit lst);
    tick();
    req_valid = 1'b1; req_addr = a; req_write = wr; req_len = LW'(len);
    req_lock = lk; req_lock_last = lst;
    #1;
    chk(req_ready == 1'b1, "R11 request slot free", 64'(req_ready), 64'd1);
    tick();
    req_valid = 1'b0;
    #1;
  endtask

  task automatic wait_ads(input string tag);
    for (int i = 0; i < 10 && !bus_ads; i++) begin
      tick();
      #1;
    end
    chk(bus_ads == 1'b1, tag, 64'(bus_ads), 64'd1);
  endtask

  task automatic run_beats(input int len, input bit is_wb, input string tag);
    for (int i = 0; i <= len; i++) begin
      tick();
      bus_brdy = 1'b1;
      #1;
      chk(bus_beat == LW'(i), {tag, " beat index"}, 64'(bus_beat), 64'(i));
      if (is_wb) chk(wb_ack == (i == len), {tag, " wb_ack"}, 64'(wb_ack), 64'(i == len));
      else chk(core_done == (i == len), {tag, " core_done"}, 64'(core_done), 64'(i == len));
    end
  endtask

  task automatic t_reset();
    chk(!bus_ads, "R10 ads after reset", 64'(bus_ads), 64'd0);
    chk(!bus_req, "R10 req after reset", 64'(bus_req), 64'd0);
    chk(!bus_lock, "R10 lock after reset", 64'(bus_lock), 64'd0);
    chk(req_ready, "R10 ready after reset", 64'(req_ready), 64'd1);
  endtask

  task automatic t_basic();
    push_req(32'h1000, 1'b1, 2, 1'b0, 1'b0);
    wait_ads("R11 strobe issued");
    chk(bus_addr == 32'h1000, "R11 address", 64'(bus_addr), 64'h1000);
    chk(bus_write == 1'b1, "R11 direction", 64'(bus_write), 64'd1);
    run_beats(2, 1'b0, "R11");
    tick(); bus_brdy = 1'b0; #1;
    chk(!bus_ads, "R4 idle clock after completion", 64'(bus_ads), 64'd0);
  endtask

  task automatic t_abort_restart();
    push_req(32'h2000, 1'b0, 3, 1'b0, 1'b0);
    wait_ads("R2 first strobe");
    for (int i = 0; i < 2; i++) begin tick(); bus_brdy = 1'b1; #1; end
    tick(); backoff = 1'b1; #1;
    chk(!core_done, "R1 no completion under backoff", 64'(core_done), 64'd0);
    tick(); bus_brdy = 1'b0; #1;
    chk(!bus_ads, "R3 no strobe while held", 64'(bus_ads), 64'd0);
    tick(); #1;
    tick(); backoff = 1'b0; #1;
    chk(!bus_ads, "R3 no strobe in release clock", 64'(bus_ads), 64'd0);
    tick(); #1;
    chk(bus_ads, "R3 replay strobe one clock after release", 64'(bus_ads), 64'd1);
    chk(bus_beat == '0, "R2 replay starts at beat 0", 64'(bus_beat), 64'd0);
    for (int i = 0; i < 3; i++) begin tick(); bus_brdy = 1'b1; #1; end
    tick(); backoff = 1'b1; #1;
    chk(bus_beat == 2'd3, "R1 backoff on final beat", 64'(bus_beat), 64'd3);
    chk(!core_done, "R1 final beat with backoff not completed", 64'(core_done), 64'd0);
    tick(); bus_brdy = 1'b0; #1;
    tick(); backoff = 1'b0; #1;
    tick(); #1;
    chk(bus_ads && bus_addr == 32'h2000, "R2 third run strobe", 64'(bus_addr), 64'h2000);
    run_beats(3, 1'b0, "R2 full replay");
    tick(); bus_brdy = 1'b0; #1;
  endtask

  task automatic t_stuck();
    push_req(32'h3000, 1'b0, 1, 1'b0, 1'b0);
    wait_ads("R5 strobe issued");
    backoff = 1'b1;
    tick(); #1;
    chk(!bus_ads, "R5 strobe off while held", 64'(bus_ads), 64'd0);
    tick(); backoff = 1'b0; #1;
    chk(bus_ads, "R5 strobe in first released clock", 64'(bus_ads), 64'd1);
    chk(bus_beat == '0, "R5 beat zero", 64'(bus_beat), 64'd0);
    run_beats(1, 1'b0, "R5 data follows directly");
    tick(); bus_brdy = 1'b0; #1;
  endtask

  task automatic t_no_replay();
    push_req(32'h4000, 1'b0, 0, 1'b0, 1'b0);
    wait_ads("R6 strobe A");
    run_beats(0, 1'b0, "R6 A");
    tick(); bus_brdy = 1'b0; backoff = 1'b1;
    req_valid = 1'b1; req_addr = 32'h4400; req_write = 1'b0; req_len = '0;
    req_lock = 1'b0; req_lock_last = 1'b0;
    #1;
    chk(req_ready, "R6 slot free after completion", 64'(req_ready), 64'd1);
    tick(); req_valid = 1'b0; #1;
    tick(); backoff = 1'b0; #1;
    wait_ads("R6 strobe after release");
    chk(bus_addr == 32'h4400, "R6 next request not replayed one", 64'(bus_addr), 64'h4400);
    run_beats(0, 1'b0, "R6 B");
    tick(); bus_brdy = 1'b0; #1;
  endtask

  task automatic t_wb_priority();
    push_req(32'h5000, 1'b0, 1, 1'b0, 1'b0);
    wait_ads("R7 core strobe");
    tick(); bus_brdy = 1'b1; #1;
    tick(); bus_brdy = 1'b0; backoff = 1'b1; wb_req = 1'b1; wb_addr = 32'h9F00; #1;
    chk(!core_done, "R1 held cycle not done", 64'(core_done), 64'd0);
    tick(); #1;
    tick(); backoff = 1'b0; #1;
    chk(!bus_ads, "R3 release clock quiet", 64'(bus_ads), 64'd0);
    tick(); #1;
    chk(bus_ads && bus_addr == 32'h9F00, "R7 writeback first", 64'(bus_addr), 64'h9F00);
    chk(bus_write, "R7 writeback is a write", 64'(bus_write), 64'd1);
    run_beats(3, 1'b1, "R7 writeback");
    tick(); bus_brdy = 1'b0; wb_req = 1'b0; #1;
    chk(!bus_ads, "R4 idle clock after writeback", 64'(bus_ads), 64'd0);
    tick(); #1;
    chk(bus_ads && bus_addr == 32'h5000, "R4 replay two clocks after writeback", 64'(bus_addr), 64'h5000);
    chk(bus_write == 1'b0, "R7 replay direction", 64'(bus_write), 64'd0);
    run_beats(1, 1'b0, "R7 replay");
    tick(); bus_brdy = 1'b0; #1;
  endtask

  task automatic t_stall();
    tick(); #1;
    chk(!bus_req, "R8 no request when idle", 64'(bus_req), 64'd0);
    for (int i = 0; i < 4; i++) begin
      tick(); backoff = 1'b1; core_stall = 1'b1; #1;
      chk(bus_req, "R8 request held while stalled", 64'(bus_req), 64'd1);
    end
    tick(); backoff = 1'b0; core_stall = 1'b0; #1;
    chk(!bus_req, "R8 request dropped", 64'(bus_req), 64'd0);
  endtask

  task automatic t_lock();
    push_req(32'h6000, 1'b1, 0, 1'b1, 1'b0);
    wait_ads("R9 first locked strobe");
    chk(bus_lock, "R9 lock with strobe", 64'(bus_lock), 64'd1);
    run_beats(0, 1'b0, "R9 first");
    tick(); bus_brdy = 1'b0; #1;
    chk(bus_lock, "R9 lock between cycles", 64'(bus_lock), 64'd1);
    push_req(32'h6040, 1'b0, 1, 1'b1, 1'b1);
    wait_ads("R9 last locked strobe");
    tick(); bus_brdy = 1'b1; #1;
    tick(); bus_brdy = 1'b0; backoff = 1'b1; #1;
    chk(bus_lock, "R9 lock during backoff", 64'(bus_lock), 64'd1);
    tick(); #1;
    tick(); backoff = 1'b0; #1;
    chk(bus_lock, "R9 lock at release", 64'(bus_lock), 64'd1);
    wait_ads("R9 locked replay");
    chk(bus_addr == 32'h6040, "R9 replayed address", 64'(bus_addr), 64'h6040);
    run_beats(1, 1'b0, "R9 last");
    tick(); bus_brdy = 1'b0; #1;
    chk(!bus_lock, "R9 lock released after last", 64'(bus_lock), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    #1;
    t_reset();
    t_basic();
    t_abort_restart();
    t_stuck();
    t_no_replay();
    t_wb_priority();
    t_stall();
    t_lock();
    repeat (3) tick();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule